// File: doc/BRIEF.md
# Variable-Width Call Depth Counter

This block updates a small call-depth field held in a status word. The width of the counter inside the field is not fixed. It is set by the field itself: a run of ones starting at the most significant bit, followed by a zero, selects the width. The bits below that zero hold the count. A longer prefix of ones therefore leaves fewer count bits, and the counter wraps sooner.

A call site asks for an increment and a return site asks for a decrement. An exception-return site asks only whether the count is zero. The block returns the new field and the enable bit to write back, together with an overflow flag, an underflow flag and the zero flag. It is purely combinational. The field value with every bit set turns counting off. An enable input from the status word also gates the increment and the decrement.

Top module: `cdc_depth_ctr`

## Requirements
- R1: When `field_i` has every bit set, the field is returned unchanged, `ovf_o` and `unf_o` are 0 and `zero_o` is 1, whatever the operation and enable.
- R2: The count is the low `FW-n` bits of the field, where n is the number of consecutive ones counted downward from the top bit. A field of n ones followed by all zeros has a count of zero.
- R3: For increment (`op_i`=2'b01) with `en_i`=1, if the count of `field_i+1` is nonzero, `field_o` is `field_i+1` and `ovf_o` is 0.
- R4: For increment with `en_i`=1, if the count of `field_i+1` is zero, `field_o` equals `field_i` and `ovf_o` is 1.
- R5: For decrement (`op_i`=2'b10) with `en_i`=1, if the count of `field_i` is nonzero, `field_o` is `field_i-1` and `unf_o` is 0.
- R6: For decrement with `en_i`=1, if the count of `field_i` is zero, `field_o` equals `field_i` and `unf_o` is 1.
- R7: `zero_o` is 1 exactly when the count of `field_i` is zero or the field is all ones. It does not depend on `op_i` or `en_i`.
- R8: With `en_i`=0, increment and decrement return `field_i` unchanged and raise no flag.
- R9: For increment, `en_o` is 1. For every other operation, `en_o` equals `en_i`.
- R10: Hold (`op_i`=2'b00) and zero test (`op_i`=2'b11) return `field_i` unchanged and raise neither `ovf_o` nor `unf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| field_i | input | FW (7) | Current call-depth field |
| en_i | input | 1 | Counting enable from the status word |
| op_i | input | 2 | Operation: 00 hold, 01 increment, 10 decrement, 11 zero test |
| field_o | output | FW (7) | Updated call-depth field |
| en_o | output | 1 | Enable bit to write back |
| ovf_o | output | 1 | Increment would overflow the current width |
| unf_o | output | 1 | Decrement of a zero count |
| zero_o | output | 1 | Count is zero or counting is off |

## Verification
Every one of the 128 field values is applied under each of the four operations, with the enable both set and clear. This separates width decoding errors at every prefix length from plain adder errors. It also shows where each width wraps: the last value before each prefix boundary, such as 0111111 and 1011111, must overflow instead of carrying into the separator. The value 1111110, which has no count bits at all, and the all-ones value are also applied on their own as directed cases. They show that the disable code is kept apart from the degenerate zero-width counter.

// File: rtl/cdc_depth_pkg.sv
package cdc_depth_pkg;
  typedef enum logic [1:0] {
    CDC_HOLD = 2'b00,
    CDC_INC  = 2'b01,
    CDC_DEC  = 2'b10,
    CDC_TEST = 2'b11
  } cdc_op_e;
endpackage

// File: rtl/cdc_lead_ones.sv
module cdc_lead_ones #(
  parameter  int FW = 7,
  localparam int NW = $clog2(FW + 1)
) (
  input  logic [FW-1:0] field_i,
  output logic [NW-1:0] n_o
);
  // priority scan from the top bit: stops at the first zero
  always_comb begin
    logic run;
    run = 1'b1;
    n_o = '0;
    for (int i = FW - 1; i >= 0; i--) begin
      run = run & field_i[i];
      n_o = n_o + NW'(run);
    end
  end
endmodule

// File: rtl/cdc_count_view.sv
module cdc_count_view #(
  parameter  int FW = 7,
  localparam int NW = $clog2(FW + 1)
) (
  input  logic [FW-1:0] field_i,
  input  logic [NW-1:0] n_i,
  output logic          cnt_zero_o
);
  logic [FW-1:0] mask;

  for (genvar i = 0; i < FW; i++) begin : g_mask
    assign mask[i] = (int'(n_i) + i) < FW;
  end

  assign cnt_zero_o = ~|(field_i & mask);
endmodule

// File: rtl/cdc_depth_ctr.sv
module cdc_depth_ctr
  import cdc_depth_pkg::*;
#(
  parameter int FW = 7
) (
  input  logic [FW-1:0] field_i,
  input  logic          en_i,
  input  logic [1:0]    op_i,
  output logic [FW-1:0] field_o,
  output logic          en_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          zero_o
);
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0] field_p1, field_m1;
  logic [NW-1:0] n_cur, n_nxt;
  logic          cur_zero, nxt_zero;
  logic          disabled, active;
  cdc_op_e       op;

  assign field_p1 = field_i + 1'b1;
  assign field_m1 = field_i - 1'b1;
  assign disabled = &field_i;
  assign active   = en_i & ~disabled;
  assign op       = cdc_op_e'(op_i);

  cdc_lead_ones  #(.FW(FW)) u_lo_cur (.field_i(field_i),  .n_o(n_cur));
  cdc_lead_ones  #(.FW(FW)) u_lo_nxt (.field_i(field_p1), .n_o(n_nxt));
  cdc_count_view #(.FW(FW)) u_cv_cur (.field_i(field_i),  .n_i(n_cur), .cnt_zero_o(cur_zero));
  // overflow: the carry reached the separator, so the new width holds zero
  cdc_count_view #(.FW(FW)) u_cv_nxt (.field_i(field_p1), .n_i(n_nxt), .cnt_zero_o(nxt_zero));

  always_comb begin
    field_o = field_i;
    en_o    = en_i;
    ovf_o   = 1'b0;
    unf_o   = 1'b0;
    unique case (op)
      CDC_INC: begin
        en_o = 1'b1;
        if (active) begin
          if (nxt_zero) ovf_o   = 1'b1;
          else          field_o = field_p1;
        end
      end
      CDC_DEC: begin
        if (active) begin
          if (cur_zero) unf_o   = 1'b1;
          else          field_o = field_m1;
        end
      end
      default: ;
    endcase
  end

  assign zero_o = disabled | cur_zero;
endmodule

// File: rtl/cdc_depth_ctr_chk.sv
module cdc_depth_ctr_chk #(
  parameter int FW = 7
) (
  input logic [FW-1:0] field_i,
  input logic          en_i,
  input logic [1:0]    op_i,
  input logic [FW-1:0] field_o,
  input logic          en_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          zero_o
);
  always_comb begin
    if (&field_i) begin
      assert_off_code_R1: assert (field_o == field_i && !ovf_o && !unf_o && zero_o)
        else $error("R1 violated");
    end
    assert_flags_excl_R4: assert (!(ovf_o && unf_o)) else $error("R4/R6 flags both set");
    if (ovf_o) begin
      assert_no_overflow_R4: assert (field_o == field_i && op_i == 2'b01)
        else $error("R4 overflow changed field");
    end
    if (unf_o) begin
      assert_no_underflow_R6: assert (field_o == field_i && op_i == 2'b10)
        else $error("R6 underflow changed field");
    end
    if (op_i == 2'b01 && field_o != field_i) begin
      assert_inc_step_R3: assert (field_o == field_i + 1'b1) else $error("R3 bad step");
    end
    if (op_i == 2'b10 && field_o != field_i) begin
      assert_dec_step_R5: assert (field_o == field_i - 1'b1) else $error("R5 bad step");
    end
    if (!en_i) begin
      assert_gated_R8: assert (field_o == field_i && !ovf_o && !unf_o) else $error("R8 violated");
    end
    assert_en_out_R9: assert (op_i == 2'b01 ? en_o : (en_o == en_i)) else $error("R9 violated");
    if (op_i == 2'b00 || op_i == 2'b11) begin
      assert_passive_R10: assert (field_o == field_i && !ovf_o && !unf_o)
        else $error("R10 violated");
    end
    if (field_o != field_i) begin
      assert_moved_nonzero_R7: assert (op_i != 2'b10 || !zero_o) else $error("R7 violated");
    end
  end
endmodule

bind cdc_depth_ctr cdc_depth_ctr_chk #(.FW(FW)) u_chk (
  .field_i(field_i), .en_i(en_i), .op_i(op_i), .field_o(field_o),
  .en_o(en_o), .ovf_o(ovf_o), .unf_o(unf_o), .zero_o(zero_o)
);

// File: tb/cdc_depth_ctr_tb.sv
module cdc_depth_ctr_tb;
  localparam int FW = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [FW-1:0] field_i, field_o;
  logic en_i, en_o, ovf_o, unf_o, zero_o;
  logic [1:0] op_i;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cdc_depth_ctr #(.FW(FW)) u_dut (
    .field_i(field_i), .en_i(en_i), .op_i(op_i), .field_o(field_o),
    .en_o(en_o), .ovf_o(ovf_o), .unf_o(unf_o), .zero_o(zero_o)
  );

  function automatic logic cnt_is_zero(logic [FW-1:0] f);
    int n = 0;
    logic [FW-1:0] m;
    for (int i = FW - 1; i >= 0; i--) begin
      if (f[i]) n++;
      else break;
    end
    m = '0;
    for (int i = 0; i < FW - n; i++) m[i] = 1'b1;
    return (f & m) == '0;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (field %b op %b en %b)",
               req, what, act, exp, field_i, op_i, en_i);
    end
  endtask

  task automatic apply(logic [FW-1:0] f, logic e, logic [1:0] o);
    @(posedge clk);
    field_i = f; en_i = e; op_i = o;
    @(negedge clk);
  endtask

  // full expected behaviour, computed from the requirements
  task automatic check_one(logic [FW-1:0] f, logic e, logic [1:0] o);
    logic [FW-1:0] ef = f;
    logic eo = (o == 2'b01) ? 1'b1 : e;
    logic ov = 0, un = 0;
    logic ez = (&f) || cnt_is_zero(f);
    string tag = "R10";
    apply(f, e, o);
    if (&f) tag = "R1";
    else if (!e && (o == 2'b01 || o == 2'b10)) tag = "R8";
    else if (o == 2'b01) begin
      if (cnt_is_zero(FW'(f + 1'b1))) begin ov = 1; tag = "R4"; end
      else begin ef = f + 1'b1; tag = "R3"; end
    end else if (o == 2'b10) begin
      if (cnt_is_zero(f)) begin un = 1; tag = "R6"; end
      else begin ef = f - 1'b1; tag = "R5"; end
    end
    chk(tag, int'(field_o), int'(ef), "field");
    chk(tag, int'(ovf_o), int'(ov), "ovf");
    chk(tag, int'(unf_o), int'(un), "unf");
    chk("R7", int'(zero_o), int'(ez), "zero");
    chk("R9", int'(en_o), int'(eo), "en_out");
  endtask

  task automatic t_idle();
    apply('0, 1'b0, 2'b00);
    chk("R10", int'(field_o), 0, "idle field");
    chk("R10", int'(ovf_o | unf_o), 0, "idle flags");
    chk("R7", int'(zero_o), 1, "idle zero");
    chk("R9", int'(en_o), 0, "idle en");
  endtask

  task automatic t_sweep(logic [1:0] o, logic e);
    for (int v = 0; v < (1 << FW); v++) check_one(FW'(v), e, o);
  endtask

  task automatic t_corners();
    apply(7'b0111111, 1'b1, 2'b01);
    chk("R4", int'(ovf_o), 1, "wrap at top width");
    chk("R4", int'(field_o), 7'b0111111, "field kept");
    apply(7'b1011110, 1'b1, 2'b01);
    chk("R3", int'(field_o), 7'b1011111, "step");
    apply(7'b1011111, 1'b1, 2'b01);
    chk("R4", int'(ovf_o), 1, "wrap at 5 bits");
    apply(7'b1111110, 1'b1, 2'b01);
    chk("R4", int'(ovf_o), 1, "zero-width counter");
    apply(7'b1100000, 1'b1, 2'b10);
    chk("R6", int'(unf_o), 1, "underflow");
    apply(7'b1000001, 1'b1, 2'b10);
    chk("R5", int'(field_o), 7'b1000000, "dec");
    apply(7'b1110000, 1'b1, 2'b11);
    chk("R2", int'(zero_o), 1, "prefix 3 count 0");
    apply(7'b1101111, 1'b1, 2'b11);
    chk("R2", int'(zero_o), 0, "prefix 2 count 15");
    apply(7'b1111111, 1'b1, 2'b01);
    chk("R1", int'(field_o), 7'b1111111, "off code kept");
    chk("R1", int'(ovf_o), 0, "off code no ovf");
    apply(7'b0000011, 1'b0, 2'b01);
    chk("R8", int'(field_o), 7'b0000011, "gated inc");
    chk("R9", int'(en_o), 1, "inc sets en");
  endtask

  initial begin
    field_i = '0; en_i = 1'b0; op_i = 2'b00;
    t_idle();
    t_corners();
    for (int o = 0; o < 4; o++) begin
      t_sweep(2'(o), 1'b1);
      t_sweep(2'(o), 1'b0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule